// File: doc/BRIEF.md
# Masked-Write Clock Tuning Control Bank

This block stores the clock tuning settings for a set of card-interface controllers (four by default). Each controller owns two 16-bit control words on a 32-bit register bus. One word steers the clock that drives the card. The other steers the clock that samples data coming back. Software writes a word with a per-bit enable mask in the upper half of the same data word, so it can change one field without first reading the word back.

From the stored words, the block slices out three fields for every controller and clock kind:
- a 2-bit phase code (0, 90, 180 or 270 degrees);
- an 8-bit delay count;
- a mode bit that chooses between the phase-shifted clock alone and the phase-shifted clock passed through the delay line.

These fields are held in flops and go straight to the clock-phase logic downstream.

Top module: `tune_ctl_bank`

## Requirements
- R1: The word for controller c (0 to N_CTRL-1) and clock kind k (0 = drive, 1 = sample) is at byte address BASE + 8*c + 4*k.
- R2: On a write to a mapped word, stored bit n (0 to 15) takes wdata[n] only when wdata[n+16] is 1. Otherwise it keeps its value.
- R3: For a drive word, the phase output is bits 1:0, the delay output is bits 9:2 and the mode output is bit 10.
- R4: For a sample word, the phase output is bits 2:1, the delay output is bits 10:3 and the mode output is bit 11.
- R5: Phase codes 0..3 (meaning 0/90/180/270 degrees) and delay counts over the full range 0 to 255 reach the outputs unchanged. Mode 0 means phase only and mode 1 means phase plus delay line, and both values pass through.
- R6: A read returns the addressed word on rdata in the cycle after rd_en. rdata[15:0] holds the stored bits, rdata[31:16] is zero, and rdata keeps its value until the next read.
- R7: Synchronous reset clears every stored word, every field output and rdata to zero.
- R8: A write to an unmapped or non-word-aligned address changes nothing. A read of such an address returns zero.
- R9: When a read and a write hit the same word in the same cycle, the read returns the value from before the write. Field outputs show a write from the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data: mask in [31:16], value in [15:0] |
| rdata | output | 32 | Registered read data |
| drv_phase | output | 2*N_CTRL | Drive-clock phase code, 2 bits per controller |
| drv_delay | output | 8*N_CTRL | Drive-clock delay count, 8 bits per controller |
| drv_mode | output | N_CTRL | Drive-clock mode bit per controller |
| smp_phase | output | 2*N_CTRL | Sample-clock phase code, 2 bits per controller |
| smp_delay | output | 8*N_CTRL | Sample-clock delay count, 8 bits per controller |
| smp_mode | output | N_CTRL | Sample-clock mode bit per controller |

## Verification
The assertions run on every cycle. They check these rules:
- a write with an all-zero mask leaves the target controller's fields untouched;
- a full-mask write lands in the fields at the positions for that word's kind;
- writes to unmapped addresses leave all outputs still;
- the upper half of read data is zero, and unmapped reads return zero;
- reset clears everything.

Only the bench's scenarios can show the following:
- partial-mask merges that keep some old bits and replace others;
- that neighbouring words are untouched;
- the extreme delay values;
- the old-value result of a read that collides with a write;
- read-back of bits that lie outside every field.

// File: rtl/tune_pkg.sv
package tune_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;
  localparam int PH_W   = 2;
  localparam int DLY_W  = 8;

  typedef enum logic [0:0] {
    CLK_DRIVE  = 1'b0,
    CLK_SAMPLE = 1'b1
  } clk_kind_e;

  // Field placement depends on the word kind; downstream logic relies on it.
  function automatic int ph_lsb(input int is_sample);
    return (is_sample != 0) ? 1 : 0;
  endfunction

  function automatic int dly_lsb(input int is_sample);
    return (is_sample != 0) ? 3 : 2;
  endfunction

  function automatic int mode_pos(input int is_sample);
    return (is_sample != 0) ? 11 : 10;
  endfunction
endpackage

// File: rtl/tune_addr_dec.sv
module tune_addr_dec #(
  parameter int ADDR_W = 12,
  parameter int N_CTRL = 4,
  parameter logic [ADDR_W-1:0] BASE = 12'h140,
  localparam int N_WORDS = 2 * N_CTRL,
  localparam int IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  word_idx
);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(4 * N_WORDS);

  logic [ADDR_W-1:0] off;

  always_comb begin
    off      = addr - BASE;
    hit      = (addr >= BASE) && (off < SPAN) && (off[1:0] == 2'b00);
    word_idx = off[IDX_W+1:2];
  end
endmodule

// File: rtl/tune_word.sv
module tune_word #(
  parameter int IS_SAMPLE = 0,
  localparam int HW = tune_pkg::HALF_W,
  localparam int PL = tune_pkg::ph_lsb(IS_SAMPLE),
  localparam int DL = tune_pkg::dly_lsb(IS_SAMPLE),
  localparam int MB = tune_pkg::mode_pos(IS_SAMPLE)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [tune_pkg::WORD_W-1:0] wdata,
  output logic [HW-1:0]              q,
  output logic [tune_pkg::PH_W-1:0]  phase,
  output logic [tune_pkg::DLY_W-1:0] delay,
  output logic                       mode
);
  logic [HW-1:0] mask;
  logic [HW-1:0] val;

  always_comb begin
    mask = wdata[2*HW-1:HW];
    val  = wdata[HW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (we) begin
      q <= (q & ~mask) | (val & mask);
    end
  end

  always_comb begin
    phase = q[PL +: tune_pkg::PH_W];
    delay = q[DL +: tune_pkg::DLY_W];
    mode  = q[MB];
  end
endmodule

// File: rtl/tune_ctl_bank.sv
module tune_ctl_bank #(
  parameter int ADDR_W = 12,
  parameter int N_CTRL = 4,
  parameter logic [ADDR_W-1:0] BASE = 12'h140,
  localparam int N_WORDS = 2 * N_CTRL,
  localparam int IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
  localparam int PW = tune_pkg::PH_W,
  localparam int DW = tune_pkg::DLY_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [PW*N_CTRL-1:0] drv_phase,
  output logic [DW*N_CTRL-1:0] drv_delay,
  output logic [N_CTRL-1:0]    drv_mode,
  output logic [PW*N_CTRL-1:0] smp_phase,
  output logic [DW*N_CTRL-1:0] smp_delay,
  output logic [N_CTRL-1:0]    smp_mode
);
  logic             hit;
  logic [IDX_W-1:0] idx;
  logic [tune_pkg::HALF_W-1:0] words [N_WORDS];

  tune_addr_dec #(.ADDR_W(ADDR_W), .N_CTRL(N_CTRL), .BASE(BASE)) u_dec (
    .addr(addr), .hit(hit), .word_idx(idx)
  );

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    localparam int C = w / 2;
    localparam int IS_S = w % 2;
    logic [PW-1:0] ph;
    logic [DW-1:0] dl;
    logic          md;

    tune_word #(.IS_SAMPLE(IS_S)) u_word (
      .clk(clk), .rst(rst),
      .we(wr_en && hit && (idx == IDX_W'(w))),
      .wdata(wdata), .q(words[w]),
      .phase(ph), .delay(dl), .mode(md)
    );

    if (IS_S == int'(tune_pkg::CLK_SAMPLE)) begin : g_smp
      assign smp_phase[PW*C +: PW] = ph;
      assign smp_delay[DW*C +: DW] = dl;
      assign smp_mode[C]           = md;
    end else begin : g_drv
      assign drv_phase[PW*C +: PW] = ph;
      assign drv_delay[DW*C +: DW] = dl;
      assign drv_mode[C]           = md;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= hit ? {16'h0000, words[idx]} : 32'h0;
    end
  end
endmodule

// File: rtl/tune_ctl_bank_chk.sv
module tune_ctl_bank_chk #(
  parameter int ADDR_W = 12,
  parameter int N_CTRL = 4,
  parameter logic [ADDR_W-1:0] BASE = 12'h140
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic [2*N_CTRL-1:0] drv_phase,
  input logic [8*N_CTRL-1:0] drv_delay,
  input logic [N_CTRL-1:0]   drv_mode,
  input logic [2*N_CTRL-1:0] smp_phase,
  input logic [8*N_CTRL-1:0] smp_delay,
  input logic [N_CTRL-1:0]   smp_mode
);
  logic mapped;
  always_comb begin
    mapped = (int'(addr) >= int'(BASE)) && (int'(addr) < int'(BASE) + 8 * N_CTRL)
             && (addr[1:0] == 2'b00);
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (rdata == 32'h0) && (drv_phase == '0) && (drv_delay == '0) && (drv_mode == '0)
            && (smp_phase == '0) && (smp_delay == '0) && (smp_mode == '0)); // R7

  AST_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (rdata[31:16] == 16'h0)); // R6

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !mapped) |=> (rdata == 32'h0)); // R8

  AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !mapped) |=> ($stable(drv_phase) && $stable(drv_delay) && $stable(drv_mode)
                            && $stable(smp_phase) && $stable(smp_delay) && $stable(smp_mode))); // R8

  for (genvar c = 0; c < N_CTRL; c++) begin : g_c
    localparam logic [ADDR_W-1:0] A_DRV = BASE + ADDR_W'(8 * c);
    localparam logic [ADDR_W-1:0] A_SMP = BASE + ADDR_W'(8 * c + 4);

    AST_NO_MASK_HOLDS_DRV: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == A_DRV && wdata[31:16] == 16'h0) |=>
        ($stable(drv_phase[2*c +: 2]) && $stable(drv_delay[8*c +: 8]) && $stable(drv_mode[c]))); // R2

    AST_NO_MASK_HOLDS_SMP: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == A_SMP && wdata[31:16] == 16'h0) |=>
        ($stable(smp_phase[2*c +: 2]) && $stable(smp_delay[8*c +: 8]) && $stable(smp_mode[c]))); // R2

    AST_FULL_WRITE_DRV: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == A_DRV && wdata[31:16] == 16'hFFFF) |=>
        ((drv_phase[2*c +: 2] == $past(wdata[1:0])) && (drv_delay[8*c +: 8] == $past(wdata[9:2]))
         && (drv_mode[c] == $past(wdata[10])))); // R3

    AST_FULL_WRITE_SMP: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == A_SMP && wdata[31:16] == 16'hFFFF) |=>
        ((smp_phase[2*c +: 2] == $past(wdata[2:1])) && (smp_delay[8*c +: 8] == $past(wdata[10:3]))
         && (smp_mode[c] == $past(wdata[11])))); // R4
  end
endmodule

bind tune_ctl_bank tune_ctl_bank_chk #(.ADDR_W(ADDR_W), .N_CTRL(N_CTRL), .BASE(BASE)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .drv_phase(drv_phase), .drv_delay(drv_delay), .drv_mode(drv_mode),
  .smp_phase(smp_phase), .smp_delay(smp_delay), .smp_mode(smp_mode)
);

// File: tb/sim_tune_ctl_bank.sv
module sim_tune_ctl_bank;
  localparam int ADDR_W = 12;
  localparam int NC = 4;
  localparam logic [ADDR_W-1:0] BASE = 12'h140;
  localparam int NV = 21;

  // vector: op (0 write, 1 read), address, data (for a read: expected rdata[15:0])
  localparam logic [44:0] VEC [NV] = '{
    {1'b0, 12'h140, 32'h07FF_0405},
    {1'b1, 12'h140, 32'h0000_0405},
    {1'b0, 12'h140, 32'h0003_FFFF},
    {1'b1, 12'h140, 32'h0000_0407},
    {1'b0, 12'h144, 32'hFFFF_ABCD},
    {1'b1, 12'h144, 32'h0000_ABCD},
    {1'b0, 12'h144, 32'h0000_FFFF},
    {1'b1, 12'h144, 32'h0000_ABCD},
    {1'b0, 12'h15C, 32'h0FF0_1234},
    {1'b1, 12'h15C, 32'h0000_0230},
    {1'b0, 12'h160, 32'hFFFF_FFFF},
    {1'b1, 12'h160, 32'h0000_0000},
    {1'b0, 12'h142, 32'hFFFF_FFFF},
    {1'b1, 12'h140, 32'h0000_0407},
    {1'b1, 12'h142, 32'h0000_0000},
    {1'b0, 12'h13C, 32'hFFFF_FFFF},
    {1'b1, 12'h13C, 32'h0000_0000},
    {1'b0, 12'h148, 32'hFFFF_5A5A},
    {1'b1, 12'h148, 32'h0000_5A5A},
    {1'b1, 12'h14C, 32'h0000_0000},
    {1'b1, 12'h150, 32'h0000_0000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2*NC-1:0] drv_phase, smp_phase;
  logic [8*NC-1:0] drv_delay, smp_delay;
  logic [NC-1:0]   drv_mode, smp_mode;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [15:0] mdl [2*NC];

  always #4 clk = ~clk;

  tune_ctl_bank #(.ADDR_W(ADDR_W), .N_CTRL(NC), .BASE(BASE)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .drv_phase(drv_phase), .drv_delay(drv_delay), .drv_mode(drv_mode),
    .smp_phase(smp_phase), .smp_delay(smp_delay), .smp_mode(smp_mode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Model of R1/R2/R8: mapped words only, masked merge.
  task automatic model_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    int off = int'(a) - int'(BASE);
    if (off >= 0 && off < 8 * NC && (off % 4) == 0)
      mdl[off / 4] = (mdl[off / 4] & ~d[31:16]) | (d[15:0] & d[31:16]);
  endtask

  // R3 / R4 field positions, checked against the model
  task automatic check_fields();
    for (int c = 0; c < NC; c++) begin
      logic [15:0] dw = mdl[2*c];
      logic [15:0] sw = mdl[2*c+1];
      check("R3 drv_phase", 32'(drv_phase[2*c +: 2]), 32'(dw[1:0]));
      check("R3 drv_delay", 32'(drv_delay[8*c +: 8]), 32'(dw[9:2]));
      check("R3 drv_mode",  32'(drv_mode[c]),         32'(dw[10]));
      check("R4 smp_phase", 32'(smp_phase[2*c +: 2]), 32'(sw[2:1]));
      check("R4 smp_delay", 32'(smp_delay[8*c +: 8]), 32'(sw[10:3]));
      check("R4 smp_mode",  32'(smp_mode[c]),         32'(sw[11]));
    end
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, input string req, input logic [31:0] exp);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check(req, rdata, exp);
  endtask

  initial begin
    for (int i = 0; i < 2 * NC; i++) mdl[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7: reset state
    check("R7 rdata", rdata, 32'h0);
    check_fields();

    // R1 R2 R6 R8 vector walk
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][44] == 1'b0) begin
        do_write(VEC[v][43:32], VEC[v][31:0]);
        check_fields();
      end else begin
        do_read(VEC[v][43:32], "R1/R2/R6/R8 read", {16'h0, VEC[v][15:0]});
      end
    end

    // R6: rdata holds after the read strobe drops
    @(negedge clk);
    @(negedge clk);
    check("R6 rdata hold", rdata, 32'h0);
    do_read(12'h144, "R6 read", 32'h0000_ABCD);
    repeat (3) @(negedge clk);
    check("R6 rdata hold", rdata, 32'h0000_ABCD);

    // R5: delay extremes and every phase code
    do_write(12'h150, 32'h07FF_07FF);
    check("R5 delay 255", 32'(drv_delay[16 +: 8]), 32'hFF);
    check("R5 mode 1", 32'(drv_mode[2]), 32'h1);
    do_write(12'h150, 32'h07FC_0000);
    check("R5 delay 0", 32'(drv_delay[16 +: 8]), 32'h0);
    check("R5 mode 0", 32'(drv_mode[2]), 32'h0);
    for (int p = 0; p < 4; p++) begin
      do_write(12'h154, {16'h0006, 13'h0, 2'(p), 1'b0});
      check("R5 smp phase code", 32'(smp_phase[4 +: 2]), 32'(p));
    end
    check_fields();

    // R9: read and write to the same word in one cycle returns old value
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b1; addr = 12'h148; wdata = 32'hFFFF_1111;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R9 read old value", rdata, 32'h0000_5A5A);
    model_write(12'h148, 32'hFFFF_1111);
    check_fields();
    do_read(12'h148, "R9 new value", 32'h0000_1111);

    // R7: reset mid-run clears everything
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 2 * NC; i++) mdl[i] = 16'h0;
    check("R7 rdata after reset", rdata, 32'h0);
    check_fields();
    do_read(12'h140, "R7 word cleared", 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule